// File: doc/BRIEF.md
# Interlocked Strobe/Ready Parallel Port

This block is a byte-wide parallel port that moves words across a fully interlocked four-phase handshake with an external device. A direction input selects the mode. In receive mode the external device drives the data lines and an active-low data-valid strobe; the port captures the word, answers by pulling its ready line low, and raises ready again only after the strobe has gone back high and the word has been taken from the internal one-word buffer. In send mode the roles are swapped: the port drives a word, then pulls its own active-low strobe, waits for the external device to pull ready low, releases the strobe, and starts nothing new until ready has risen again.

The incoming strobe and ready lines each pass through a two-flop synchronizer before the state machines look at them. Inside the chip the receive side looks like a valid/ready source and the send side like a valid/ready sink. Each completed transfer (a captured word, or a sent word that the far side has acknowledged) produces a one-clock interrupt-request pulse.

The receive machine has states RX_IDLE, RX_HOLD and RX_FULL. RX_IDLE goes to RX_HOLD on a synchronized strobe fall while the buffer is empty (capture). RX_HOLD goes to RX_IDLE once the strobe is high and the buffer has been read, or to RX_FULL once the strobe is high with the word still unread. RX_FULL goes to RX_IDLE when the word is read. RX_IDLE also moves to RX_FULL if it finds the buffer occupied. The send machine has states TX_IDLE, TX_SETUP, TX_STROBE and TX_RELEASE. TX_IDLE goes to TX_SETUP when a word is accepted. TX_SETUP goes to TX_STROBE once synchronized ready is high. TX_STROBE goes to TX_RELEASE when synchronized ready is low (acknowledge). TX_RELEASE goes back to TX_IDLE once synchronized ready is high again. Each machine is held in its idle state while the other mode is selected.

Top module: `strobe_port`

## Requirements
- R1: After reset the outgoing strobe `pad_dav_n_out` is 1, the outgoing ready `pad_rdy_out` is 1, `rx_valid` is 0 and `irq` is 0.
- R2: In receive mode (`dir_out`=0), a fall of `pad_dav_n_in` while `pad_rdy_out` is 1 captures `pad_data_in`. `pad_rdy_out` then goes to 0, and `rx_valid`=1 with `rx_data` equal to the captured word.
- R3: In receive mode, `pad_rdy_out` stays 0 while `pad_dav_n_in` is 0, even after the buffer has been read. It returns to 1 only after `pad_dav_n_in` is back at 1 and the buffer is empty.
- R4: In receive mode, while the buffer holds an unread word, `pad_rdy_out` stays 0 even though `pad_dav_n_in` is 1. A read (`rx_valid` and `rx_ready` both 1 at a clock edge) empties the buffer, and `pad_rdy_out` then returns to 1.
- R5: In receive mode, a strobe fall that arrives while `pad_rdy_out` is 0 is ignored: `rx_data` keeps the earlier word and no `irq` pulse is raised.
- R6: In send mode (`dir_out`=1), a word accepted on `tx_valid`/`tx_ready` is on `pad_data_out` for at least one clock before `pad_dav_n_out` falls, and it stays unchanged while `pad_dav_n_out` is 0.
- R7: In send mode, `pad_dav_n_out` falls only when synchronized `pad_rdy_in` has been 1 for at least the previous clock. It stays 0 until `pad_rdy_in` goes to 0, then returns to 1. It does not fall again until `pad_rdy_in` has risen.
- R8: `irq` is a single-clock pulse, raised once for each captured input word and once for each acknowledged output word.
- R9: In receive mode `pad_dav_n_out` is 1, `tx_ready` is 0 and `pad_data_oe` is 0. In send mode `pad_rdy_out` is 1, `pad_data_oe` is 1, and `pad_dav_n_in` has no effect (`rx_valid` stays 0 and no `irq` pulse is raised).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| dir_out | input | 1 | Mode: 0 receive, 1 send |
| pad_data_in | input | 8 | Data lines from the external device |
| pad_dav_n_in | input | 1 | External active-low data-valid strobe (receive) |
| pad_rdy_out | output | 1 | Ready answer to the external device (receive) |
| pad_data_out | output | 8 | Data lines driven to the external device |
| pad_data_oe | output | 1 | Drive enable for the data lines |
| pad_dav_n_out | output | 1 | Active-low data-valid strobe driven out (send) |
| pad_rdy_in | input | 1 | Acknowledge from the external device (send) |
| rx_data | output | 8 | Buffered received word |
| rx_valid | output | 1 | Buffer holds an unread word |
| rx_ready | input | 1 | Internal consumer takes the buffered word |
| tx_data | input | 8 | Word to send |
| tx_valid | input | 1 | Word to send is offered |
| tx_ready | output | 1 | Port can accept a word to send |
| irq | output | 1 | One-clock pulse per completed transfer |

## Verification
The assertions take for granted that `dir_out` changes only while both machines are idle. They also take for granted that the external device follows the interlock: in receive mode it holds data stable from before its strobe fall until ready has fallen, and in send mode it acknowledges only a strobe that is low. The bench drives every pad input on the falling clock edge. It changes mode only between completed transfers, and it waits for each handshake edge before making the next one. Its only deliberate breach of the interlock is the R5 stimulus, an extra strobe fall while ready is low. The properties either tolerate that case or confirm that it is ignored.

// File: rtl/hs_port_pkg.sv
package hs_port_pkg;

    typedef enum logic [1:0] {
        RX_IDLE = 2'd0,
        RX_HOLD = 2'd1,
        RX_FULL = 2'd2
    } rx_state_t;

    typedef enum logic [1:0] {
        TX_IDLE    = 2'd0,
        TX_SETUP   = 2'd1,
        TX_STROBE  = 2'd2,
        TX_RELEASE = 2'd3
    } tx_state_t;

endpackage

// File: rtl/hs_sync.sv
module hs_sync #(
    parameter int               WIDTH     = 2,
    parameter int               STAGES    = 2,
    parameter logic [WIDTH-1:0] RESET_VAL = '1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);

    localparam int LAST = STAGES - 1;

    logic [STAGES-1:0][WIDTH-1:0] chain_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chain_q <= {STAGES{RESET_VAL}};
        end else begin
            chain_q <= {chain_q[LAST-1:0], async_in};
        end
    end

    assign sync_out = chain_q[LAST];

endmodule

// File: rtl/hs_rx_fsm.sv
module hs_rx_fsm
    import hs_port_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable,
    input  logic              dav_sync,
    input  logic [DATA_W-1:0] pad_data,
    input  logic              rd_ready,
    output logic              rdy,
    output logic [DATA_W-1:0] buf_data,
    output logic              buf_valid,
    output logic              done_pulse
);

    rx_state_t state_q, state_d;
    logic      dav_prev_q;
    logic      dav_fall;
    logic      capture;
    logic      drain;

    assign dav_fall = dav_prev_q && !dav_sync;
    assign capture  = enable && (state_q == RX_IDLE) && !buf_valid && dav_fall;
    assign drain    = buf_valid && rd_ready;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= RX_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        if (!enable) begin
            state_d = RX_IDLE;
        end else begin
            unique case (state_q)
                RX_IDLE: begin
                    if (capture)        state_d = RX_HOLD;
                    else if (buf_valid) state_d = RX_FULL;
                end
                RX_HOLD: begin
                    if (dav_sync) state_d = (buf_valid && !drain) ? RX_FULL : RX_IDLE;
                end
                RX_FULL: begin
                    if (drain) state_d = RX_IDLE;
                end
                default: state_d = RX_IDLE;
            endcase
        end
    end

    // outputs
    always_comb begin
        rdy = !enable || ((state_q == RX_IDLE) && !buf_valid);
    end

    // datapath: edge history, buffer, completion pulse
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dav_prev_q <= 1'b1;
            buf_data   <= '0;
            buf_valid  <= 1'b0;
            done_pulse <= 1'b0;
        end else begin
            dav_prev_q <= dav_sync;
            done_pulse <= capture;
            if (capture) begin
                buf_data  <= pad_data;
                buf_valid <= 1'b1;
            end else if (drain) begin
                buf_valid <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/hs_tx_fsm.sv
module hs_tx_fsm
    import hs_port_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable,
    input  logic              rdy_sync,
    input  logic              wr_valid,
    input  logic [DATA_W-1:0] wr_data,
    output logic              wr_ready,
    output logic              dav_n,
    output logic [DATA_W-1:0] data_out,
    output logic              done_pulse
);

    tx_state_t state_q, state_d;
    logic      accept;
    logic      acked;

    assign accept = wr_valid && wr_ready;
    assign acked  = enable && (state_q == TX_STROBE) && !rdy_sync;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= TX_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        if (!enable) begin
            state_d = TX_IDLE;
        end else begin
            unique case (state_q)
                TX_IDLE:    if (accept)    state_d = TX_SETUP;
                TX_SETUP:   if (rdy_sync)  state_d = TX_STROBE;
                TX_STROBE:  if (!rdy_sync) state_d = TX_RELEASE;
                TX_RELEASE: if (rdy_sync)  state_d = TX_IDLE;
                default:                   state_d = TX_IDLE;
            endcase
        end
    end

    // outputs
    always_comb begin
        wr_ready = enable && (state_q == TX_IDLE);
        dav_n    = (state_q != TX_STROBE);
    end

    // datapath: output word and completion pulse
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            data_out   <= '0;
            done_pulse <= 1'b0;
        end else begin
            done_pulse <= acked;
            if (accept) data_out <= wr_data;
        end
    end

endmodule

// File: rtl/strobe_port.sv
module strobe_port #(
    parameter int DATA_W      = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              dir_out,
    input  logic [DATA_W-1:0] pad_data_in,
    input  logic              pad_dav_n_in,
    output logic              pad_rdy_out,
    output logic [DATA_W-1:0] pad_data_out,
    output logic              pad_data_oe,
    output logic              pad_dav_n_out,
    input  logic              pad_rdy_in,
    output logic [DATA_W-1:0] rx_data,
    output logic              rx_valid,
    input  logic              rx_ready,
    input  logic [DATA_W-1:0] tx_data,
    input  logic              tx_valid,
    output logic              tx_ready,
    output logic              irq
);

    localparam int CTRL_W = 2;

    logic [CTRL_W-1:0] ctrl_sync;
    logic              dav_s;
    logic              rdy_s;
    logic              rx_done;
    logic              tx_done;

    hs_sync #(
        .WIDTH    (CTRL_W),
        .STAGES   (SYNC_STAGES),
        .RESET_VAL({CTRL_W{1'b1}})
    ) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_in({pad_rdy_in, pad_dav_n_in}),
        .sync_out(ctrl_sync)
    );

    assign dav_s = ctrl_sync[0];
    assign rdy_s = ctrl_sync[1];

    hs_rx_fsm #(.DATA_W(DATA_W)) u_rx (
        .clk       (clk),
        .rst_n     (rst_n),
        .enable    (!dir_out),
        .dav_sync  (dav_s),
        .pad_data  (pad_data_in),
        .rd_ready  (rx_ready),
        .rdy       (pad_rdy_out),
        .buf_data  (rx_data),
        .buf_valid (rx_valid),
        .done_pulse(rx_done)
    );

    hs_tx_fsm #(.DATA_W(DATA_W)) u_tx (
        .clk       (clk),
        .rst_n     (rst_n),
        .enable    (dir_out),
        .rdy_sync  (rdy_s),
        .wr_valid  (tx_valid),
        .wr_data   (tx_data),
        .wr_ready  (tx_ready),
        .dav_n     (pad_dav_n_out),
        .data_out  (pad_data_out),
        .done_pulse(tx_done)
    );

    assign pad_data_oe = dir_out;
    assign irq         = rx_done | tx_done;

endmodule

// File: rtl/strobe_port_chk.sv
module strobe_port_chk #(
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              dir_out,
    input logic              pad_rdy_out,
    input logic              pad_dav_n_out,
    input logic [DATA_W-1:0] pad_data_out,
    input logic              rx_valid,
    input logic              tx_ready,
    input logic              irq,
    input logic              dav_sync,
    input logic              rdy_sync
);

    // R9
    rx_mode_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !dir_out |-> (pad_dav_n_out && !tx_ready));

    // R9
    tx_mode_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dir_out |-> pad_rdy_out);

    // R2
    capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(pad_rdy_out) |-> (rx_valid && irq));

    // R3
    rdy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!dir_out && !pad_rdy_out && !dav_sync) |=> (dir_out || !pad_rdy_out));

    // R4
    full_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |-> (dir_out || !pad_rdy_out));

    // R6
    data_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !pad_dav_n_out |-> $stable(pad_data_out));

    // R7
    strobe_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(pad_dav_n_out) |-> $past(rdy_sync));

    // R7
    strobe_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!pad_dav_n_out && !rdy_sync) |=> pad_dav_n_out);

    // R8
    irq_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq |=> !irq);

endmodule

bind strobe_port strobe_port_chk #(.DATA_W(DATA_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .dir_out      (dir_out),
    .pad_rdy_out  (pad_rdy_out),
    .pad_dav_n_out(pad_dav_n_out),
    .pad_data_out (pad_data_out),
    .rx_valid     (rx_valid),
    .tx_ready     (tx_ready),
    .irq          (irq),
    .dav_sync     (dav_s),
    .rdy_sync     (rdy_s)
);

// File: tb/strobe_port_test.sv
`timescale 1ns/1ps
module strobe_port_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       dir_out = 1'b0;
    logic [7:0] pad_data_in = 8'h00;
    logic       pad_dav_n_in = 1'b1;
    logic       pad_rdy_out;
    logic [7:0] pad_data_out;
    logic       pad_data_oe;
    logic       pad_dav_n_out;
    logic       pad_rdy_in = 1'b1;
    logic [7:0] rx_data;
    logic       rx_valid;
    logic       rx_ready = 1'b0;
    logic [7:0] tx_data = 8'h00;
    logic       tx_valid = 1'b0;
    logic       tx_ready;
    logic       irq;

    int tests = 0;
    int fails = 0;
    int irq_cnt = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    strobe_port uut (
        .clk(clk), .rst_n(rst_n), .dir_out(dir_out),
        .pad_data_in(pad_data_in), .pad_dav_n_in(pad_dav_n_in),
        .pad_rdy_out(pad_rdy_out), .pad_data_out(pad_data_out),
        .pad_data_oe(pad_data_oe), .pad_dav_n_out(pad_dav_n_out),
        .pad_rdy_in(pad_rdy_in), .rx_data(rx_data), .rx_valid(rx_valid),
        .rx_ready(rx_ready), .tx_data(tx_data), .tx_valid(tx_valid),
        .tx_ready(tx_ready), .irq(irq)
    );

    always @(negedge clk) if (irq) irq_cnt <= irq_cnt + 1;

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic tick(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wait_rdy_out(logic lvl, int max, output bit ok);
        ok = 1'b0;
        for (int i = 0; i < max; i++) begin
            @(negedge clk);
            if (pad_rdy_out == lvl) begin ok = 1'b1; break; end
        end
    endtask

    task automatic wait_dav_out(logic lvl, int max, output bit ok);
        ok = 1'b0;
        for (int i = 0; i < max; i++) begin
            @(negedge clk);
            if (pad_dav_n_out == lvl) begin ok = 1'b1; break; end
        end
    endtask

    task automatic rx_read();
        @(negedge clk) rx_ready = 1'b1;
        @(negedge clk) rx_ready = 1'b0;
    endtask

    task automatic tx_offer(logic [7:0] w, output bit ok);
        ok = 1'b0;
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            if (tx_ready) begin ok = 1'b1; break; end
        end
        tx_data  = w;
        tx_valid = 1'b1;
        @(negedge clk) tx_valid = 1'b0;
    endtask

    task automatic test_reset();
        chk("R1 dav_out", pad_dav_n_out, 1);
        chk("R1 rdy_out", pad_rdy_out, 1);
        chk("R1 rx_valid", rx_valid, 0);
        chk("R1 irq", irq, 0);
    endtask

    // receive one word; reads while strobe is still low
    task automatic test_rx_word(logic [7:0] w);
        bit ok;
        int base;
        base = irq_cnt;
        @(negedge clk) pad_data_in = w;
        @(negedge clk) pad_dav_n_in = 1'b0;
        wait_rdy_out(1'b0, 10, ok);
        chk("R2 rdy fall", ok, 1);
        chk("R2 rx_valid", rx_valid, 1);
        chk("R2 rx_data", rx_data, w);
        pad_data_in = ~w;
        tick(3);
        chk("R3 rdy low while strobe low", pad_rdy_out, 0);
        chk("R8 one irq per input word", irq_cnt - base, 1);
        rx_read();
        chk("R3 buffer drained", rx_valid, 0);
        tick(2);
        chk("R3 rdy low after read, strobe low", pad_rdy_out, 0);
        pad_dav_n_in = 1'b1;
        wait_rdy_out(1'b1, 10, ok);
        chk("R3 rdy rise after strobe high", ok, 1);
        tick(2);
    endtask

    task automatic test_rx_full();
        bit ok;
        int base;
        base = irq_cnt;
        @(negedge clk) pad_data_in = 8'h3C;
        @(negedge clk) pad_dav_n_in = 1'b0;
        wait_rdy_out(1'b0, 10, ok);
        chk("R2 full-case capture", ok, 1);
        tick(2);
        pad_dav_n_in = 1'b1;
        tick(8);
        chk("R4 rdy low while buffer full", pad_rdy_out, 0);
        chk("R4 word kept", rx_valid, 1);
        // extra strobe fall while ready is low
        pad_data_in  = 8'hC3;
        pad_dav_n_in = 1'b0;
        tick(4);
        pad_dav_n_in = 1'b1;
        tick(5);
        chk("R5 ignored fall keeps data", rx_data, 8'h3C);
        chk("R5 ignored fall no irq", irq_cnt - base, 1);
        chk("R5 rdy still low", pad_rdy_out, 0);
        rx_read();
        wait_rdy_out(1'b1, 6, ok);
        chk("R4 rdy rise after read", ok, 1);
        tick(2);
    endtask

    task automatic test_tx_word(logic [7:0] w);
        bit ok;
        int base;
        base = irq_cnt;
        tx_offer(w, ok);
        chk("R6 tx_ready seen", ok, 1);
        wait_dav_out(1'b0, 10, ok);
        chk("R6 strobe fell", ok, 1);
        chk("R6 data valid at strobe", pad_data_out, w);
        tick(3);
        chk("R7 strobe held until ack", pad_dav_n_out, 0);
        chk("R6 data stable under strobe", pad_data_out, w);
        pad_rdy_in = 1'b0;
        wait_dav_out(1'b1, 10, ok);
        chk("R7 strobe released on ack", ok, 1);
        tick(2);
        chk("R8 one irq per output word", irq_cnt - base, 1);
        tick(6);
        chk("R7 no new strobe while ack low", pad_dav_n_out, 1);
        chk("R7 not ready while ack low", tx_ready, 0);
        pad_rdy_in = 1'b1;
        tick(2);
    endtask

    task automatic test_tx_wait_rdy();
        bit ok;
        pad_rdy_in = 1'b0;
        tick(4);
        tx_offer(8'h5A, ok);
        tick(8);
        chk("R7 no strobe while ack low at start", pad_dav_n_out, 1);
        chk("R6 data driven before strobe", pad_data_out, 8'h5A);
        pad_rdy_in = 1'b1;
        wait_dav_out(1'b0, 10, ok);
        chk("R7 strobe after ack rise", ok, 1);
        chk("R6 data at late strobe", pad_data_out, 8'h5A);
        pad_rdy_in = 1'b0;
        wait_dav_out(1'b1, 10, ok);
        chk("R7 release late", ok, 1);
        pad_rdy_in = 1'b1;
        tick(4);
    endtask

    task automatic test_mode_rx_side();
        chk("R9 oe off in receive", pad_data_oe, 0);
        chk("R9 tx_ready off in receive", tx_ready, 0);
        pad_rdy_in = 1'b0;
        tick(5);
        chk("R9 strobe idle in receive", pad_dav_n_out, 1);
        pad_rdy_in = 1'b1;
        tick(3);
    endtask

    task automatic test_mode_tx_side();
        int base;
        base = irq_cnt;
        chk("R9 oe on in send", pad_data_oe, 1);
        pad_data_in  = 8'h77;
        pad_dav_n_in = 1'b0;
        tick(6);
        chk("R9 rdy_out high in send", pad_rdy_out, 1);
        chk("R9 no capture in send", rx_valid, 0);
        pad_dav_n_in = 1'b1;
        tick(4);
        chk("R9 no irq in send", irq_cnt - base, 0);
    endtask

    initial begin
        tick(3);
        test_reset();
        rst_n = 1'b1;
        tick(3);
        test_rx_word(8'hA5);
        test_rx_word(8'h00);
        test_rx_word(8'hFF);
        test_rx_full();
        test_rx_word(8'h96);
        test_mode_rx_side();
        dir_out = 1'b1;
        tick(3);
        test_tx_word(8'h81);
        test_tx_word(8'h7E);
        test_tx_wait_rdy();
        test_mode_tx_side();
        dir_out = 1'b0;
        tick(3);
        test_rx_word(8'h42);
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            tests++;
            fails++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

endmodule